// File: doc/BRIEF.md
# Protocol Command Issue Interface

This block sits between a host register port and a protocol engine. The host writes a 16-bit control word. The low four bits carry a command code and bit 4 selects the write mode. When a write issues a command, the block latches the code and raises a busy flag. It then offers the code to the engine on a valid/ready pair and holds it there until the engine takes it. Overlapping commands and reserved codes are refused and recorded in a sticky illegal-command flag. The host clears that flag by writing 1 to bit 8.

A small model of the engine's operating state follows each accepted command. Most commands act on the acceptance edge. The all-slots and halt commands wait in a one-entry holding register until the communication cycle ends, which the cycle-end input signals. An engine reset command leaves the model blocked until a default-config command arrives. The host or the surrounding logic can read the state, the mode flags and the wakeup pulse directly from the ports.

Top module: `pcmd_issue`

## Requirements
- R1: After reset, busy, eng_valid, illegal, need_defcfg, coldstart_en, all_slots and wakeup_pulse are 0, cmd_field is 0 and eng_state is 0 (default config).
- R2: A write with bit 4 = 0 and a non-reserved code in bits 3:0, made while busy is 0, sets busy and eng_valid and sets cmd_field and eng_cmd to that code on the next cycle.
- R3: A write with bit 4 = 1 issues no command and leaves cmd_field, busy and eng_valid unchanged.
- R4: While eng_valid is 1 and eng_ready is 0, eng_valid and eng_cmd hold. After the edge where both are 1, busy and eng_valid are 0.
- R5: A command write made while busy is 1 is not forwarded, leaves cmd_field unchanged, and sets illegal.
- R6: Codes 1001, 1010, 1011, 1101, 1110 and 1111 are reserved. A write of one of them starts no command and sets illegal.
- R7: illegal stays set until a write with bit 8 = 1 clears it. If the same write also sets the flag, the set wins.
- R8: On acceptance, code 0010 moves eng_state to 1 (config), 0011 to 4 (halt), 0100 to 2 (ready), 0101 to 3 (startup) and 0110 to 0 (default config). Codes 0010 and 0110 also clear coldstart_en and all_slots.
- R9: Codes 0001 (all-slots) and 0111 (halt) are held after acceptance. On the first edge after that with cycle_end = 1, the held code takes effect: all_slots goes to 1, or eng_state goes to 4. A command accepted on that same edge takes precedence.
- R10: An accepted freeze (0011) discards a held all-slots or halt command.
- R11: An accepted reset (1100) sets need_defcfg and discards any held command. While need_defcfg is 1, every accepted command except 0110 has no effect. An accepted 0110 clears need_defcfg.
- R12: An accepted 0000 sets coldstart_en. An accepted 1000 gives wakeup_pulse = 1 for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe for the control word |
| host_wdata | input | 16 | Control word: [3:0] code, [4] write mode, [8] clear illegal |
| cycle_end | input | 1 | One-cycle pulse at the end of a communication cycle |
| eng_ready | input | 1 | Engine takes the offered command |
| eng_valid | output | 1 | A command is offered to the engine |
| eng_cmd | output | 4 | Offered command code |
| busy | output | 1 | A command is in flight |
| illegal | output | 1 | Sticky illegal-command flag |
| cmd_field | output | 4 | Last command code started |
| eng_state | output | 3 | Engine state: 0 default config, 1 config, 2 ready, 3 startup, 4 halt |
| need_defcfg | output | 1 | Default config is required after an engine reset |
| coldstart_en | output | 1 | Coldstart capability enabled |
| all_slots | output | 1 | All-slots transmission mode active |
| wakeup_pulse | output | 1 | One-cycle wakeup request |

## Verification
A wrong in-flight flag shows on busy and eng_valid in the cycle after the faulty write or acceptance. Every later command write is then refused or wrongly accepted, and the illegal flag shows that on the next cycle. A corrupted holding register stays hidden until the next cycle_end. At that point all_slots or eng_state differs on the following cycle, or fails to change. A wrong need_defcfg condition first shows in eng_state when the next state-changing command is accepted.

// File: rtl/pcmd_pkg.sv
package pcmd_pkg;
  localparam int PCMD_W = 4;

  localparam logic [PCMD_W-1:0] C_COLD    = 4'b0000;
  localparam logic [PCMD_W-1:0] C_ALLSLOT = 4'b0001;
  localparam logic [PCMD_W-1:0] C_CONFIG  = 4'b0010;
  localparam logic [PCMD_W-1:0] C_FREEZE  = 4'b0011;
  localparam logic [PCMD_W-1:0] C_READY   = 4'b0100;
  localparam logic [PCMD_W-1:0] C_RUN     = 4'b0101;
  localparam logic [PCMD_W-1:0] C_DEFCFG  = 4'b0110;
  localparam logic [PCMD_W-1:0] C_HALT    = 4'b0111;
  localparam logic [PCMD_W-1:0] C_WAKE    = 4'b1000;
  localparam logic [PCMD_W-1:0] C_ENGRST  = 4'b1100;

  typedef enum logic [2:0] {
    ST_DEFCFG  = 3'd0,
    ST_CONFIG  = 3'd1,
    ST_READY   = 3'd2,
    ST_STARTUP = 3'd3,
    ST_HALT    = 3'd4
  } eng_state_e;

  function automatic logic is_reserved(input logic [PCMD_W-1:0] c);
    return (c == 4'b1001) || (c == 4'b1010) || (c == 4'b1011) ||
           (c == 4'b1101) || (c == 4'b1110) || (c == 4'b1111);
  endfunction

  function automatic logic is_delayed(input logic [PCMD_W-1:0] c);
    return (c == C_ALLSLOT) || (c == C_HALT);
  endfunction

  function automatic logic is_effective(input logic need, input logic [PCMD_W-1:0] c);
    return !need || (c == C_DEFCFG);
  endfunction
endpackage

// File: rtl/pcmd_host_reg.sv
module pcmd_host_reg
  import pcmd_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int MODE_BIT = 4,
  parameter int CLR_BIT  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [WORD_W-1:0] host_wdata,
  input  logic              eng_ready,
  output logic              busy,
  output logic              illegal,
  output logic [PCMD_W-1:0] cmd_field,
  output logic              accept
);
  logic              busy_q, busy_d;
  logic              ill_q, ill_d;
  logic [PCMD_W-1:0] field_q, field_d;
  logic [PCMD_W-1:0] wr_code;
  logic              issue, refuse, start, clr_req;

  assign wr_code = host_wdata[PCMD_W-1:0];
  assign issue   = host_wr && !host_wdata[MODE_BIT];
  assign refuse  = issue && (busy_q || is_reserved(wr_code));
  assign start   = issue && !refuse;
  assign clr_req = host_wr && host_wdata[CLR_BIT];
  assign accept  = busy_q && eng_ready;

  always_comb begin
    busy_d  = busy_q;
    field_d = field_q;
    ill_d   = ill_q;
    if (start) begin
      busy_d  = 1'b1;
      field_d = wr_code;
    end else if (accept) begin
      busy_d = 1'b0;
    end
    if (refuse)       ill_d = 1'b1;
    else if (clr_req) ill_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      ill_q   <= 1'b0;
      field_q <= '0;
    end else begin
      busy_q  <= busy_d;
      ill_q   <= ill_d;
      field_q <= field_d;
    end
  end

  assign busy      = busy_q;
  assign illegal   = ill_q;
  assign cmd_field = field_q;

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !eng_ready |=> busy_q && $stable(field_q));
  assert_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && eng_ready |=> !busy_q);
  assert_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && host_wdata[MODE_BIT] |=> $stable(field_q));
  assert_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && !host_wdata[MODE_BIT] && busy_q |=> ill_q && $stable(field_q));
  assert_reserved_R6: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && !host_wdata[MODE_BIT] && !busy_q && is_reserved(host_wdata[PCMD_W-1:0])
    |=> !busy_q && ill_q);
endmodule

// File: rtl/pcmd_pend.sv
module pcmd_pend
  import pcmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [PCMD_W-1:0] acc_cmd,
  input  logic              need,
  input  logic              cycle_end,
  output logic              apply,
  output logic [PCMD_W-1:0] apply_cmd
);
  logic              pend_q, pend_d;
  logic [PCMD_W-1:0] code_q, code_d;
  logic              eff, load, cancel;

  assign eff    = accept && is_effective(need, acc_cmd);
  assign load   = eff && is_delayed(acc_cmd);
  assign cancel = eff && ((acc_cmd == C_FREEZE) || (acc_cmd == C_ENGRST));
  assign apply  = pend_q && cycle_end;
  assign apply_cmd = code_q;

  always_comb begin
    pend_d = pend_q;
    code_d = code_q;
    if (apply)  pend_d = 1'b0;
    if (load) begin
      pend_d = 1'b1;
      code_d = acc_cmd;
    end else if (cancel) begin
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      code_q <= '0;
    end else begin
      pend_q <= pend_d;
      code_q <= code_d;
    end
  end

  assert_apply_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && cycle_end && !load |=> !pend_q);
  assert_cancel_R10: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !need && acc_cmd == C_FREEZE |=> !pend_q);
  assert_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !need && acc_cmd == C_ENGRST |=> !pend_q);
endmodule

// File: rtl/pcmd_state.sv
module pcmd_state
  import pcmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [PCMD_W-1:0] acc_cmd,
  input  logic              apply,
  input  logic [PCMD_W-1:0] apply_cmd,
  output eng_state_e        state,
  output logic              need,
  output logic              cold,
  output logic              allslot,
  output logic              wake
);
  eng_state_e st_q, st_d;
  logic need_q, need_d, cold_q, cold_d, all_q, all_d, wake_q, wake_d;
  logic eff;

  assign eff = accept && is_effective(need_q, acc_cmd);

  always_comb begin
    st_d   = st_q;
    need_d = need_q;
    cold_d = cold_q;
    all_d  = all_q;
    wake_d = 1'b0;
    if (apply) begin
      if (apply_cmd == C_HALT) st_d  = ST_HALT;
      else                     all_d = 1'b1;
    end
    if (eff) begin
      unique case (acc_cmd)
        C_COLD:   cold_d = 1'b1;
        C_CONFIG: begin st_d = ST_CONFIG; cold_d = 1'b0; all_d = 1'b0; end
        C_FREEZE: st_d = ST_HALT;
        C_READY:  st_d = ST_READY;
        C_RUN:    st_d = ST_STARTUP;
        C_DEFCFG: begin
          st_d = ST_DEFCFG; need_d = 1'b0; cold_d = 1'b0; all_d = 1'b0;
        end
        C_WAKE:   wake_d = 1'b1;
        C_ENGRST: need_d = 1'b1;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_DEFCFG;
      need_q <= 1'b0;
      cold_q <= 1'b0;
      all_q  <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      need_q <= need_d;
      cold_q <= cold_d;
      all_q  <= all_d;
      wake_q <= wake_d;
    end
  end

  assign state   = st_q;
  assign need    = need_q;
  assign cold    = cold_q;
  assign allslot = all_q;
  assign wake    = wake_q;

  assert_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    need_q && !(accept && acc_cmd == C_DEFCFG) |=> $stable(st_q) && need_q);
  assert_wake_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wake_q |=> !wake_q);
  assert_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !need_q && acc_cmd == C_FREEZE |=> st_q == ST_HALT);
endmodule

// File: rtl/pcmd_issue.sv
module pcmd_issue
  import pcmd_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int MODE_BIT = 4,
  parameter int CLR_BIT  = 8,
  parameter int SYNC_STG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [WORD_W-1:0] host_wdata,
  input  logic              cycle_end,
  input  logic              eng_ready,
  output logic              eng_valid,
  output logic [3:0]        eng_cmd,
  output logic              busy,
  output logic              illegal,
  output logic [3:0]        cmd_field,
  output logic [2:0]        eng_state,
  output logic              need_defcfg,
  output logic              coldstart_en,
  output logic              all_slots,
  output logic              wakeup_pulse
);
  logic [SYNC_STG-1:0] rst_sync_q;
  logic                rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STG-2:0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[SYNC_STG-1];

  logic              accept, apply, need;
  logic [PCMD_W-1:0] field, apply_cmd;
  eng_state_e        st;

  pcmd_host_reg #(.WORD_W(WORD_W), .MODE_BIT(MODE_BIT), .CLR_BIT(CLR_BIT)) u_host (
    .clk(clk), .rst_n(rst_i_n), .host_wr(host_wr), .host_wdata(host_wdata),
    .eng_ready(eng_ready), .busy(busy), .illegal(illegal), .cmd_field(field),
    .accept(accept)
  );

  pcmd_pend u_pend (
    .clk(clk), .rst_n(rst_i_n), .accept(accept), .acc_cmd(field), .need(need),
    .cycle_end(cycle_end), .apply(apply), .apply_cmd(apply_cmd)
  );

  pcmd_state u_state (
    .clk(clk), .rst_n(rst_i_n), .accept(accept), .acc_cmd(field), .apply(apply),
    .apply_cmd(apply_cmd), .state(st), .need(need), .cold(coldstart_en),
    .allslot(all_slots), .wake(wakeup_pulse)
  );

  assign eng_valid   = busy;
  assign eng_cmd     = field;
  assign cmd_field   = field;
  assign eng_state   = st;
  assign need_defcfg = need;
endmodule

// File: tb/sim_pcmd_issue.sv
module sim_pcmd_issue;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_wr = 1'b0, cycle_end = 1'b0, eng_ready = 1'b0;
  logic [15:0] host_wdata = '0;
  logic eng_valid, busy, illegal, need_defcfg, coldstart_en, all_slots, wakeup_pulse;
  logic [3:0] eng_cmd, cmd_field;
  logic [2:0] eng_state;

  pcmd_issue u0 (.*);

  always #(CLK_P/2) clk = ~clk;

  int n_run = 0, n_fail = 0;
  logic done = 1'b0;

  // reference model state
  logic m_busy, m_ill, m_need, m_cold, m_all, m_wake, m_pend;
  logic [3:0] m_field, m_pcode;
  logic [2:0] m_state;

  function automatic logic f_res(input logic [3:0] c);
    return c inside {4'b1001, 4'b1010, 4'b1011, 4'b1101, 4'b1110, 4'b1111};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R4 busy",         busy,         m_busy);
    chk("R4 eng_valid",    eng_valid,    m_busy);
    chk("R2 eng_cmd",      eng_cmd,      m_field);
    chk("R3 cmd_field",    cmd_field,    m_field);
    chk("R7 illegal",      illegal,      m_ill);
    chk("R8 eng_state",    eng_state,    m_state);
    chk("R11 need_defcfg", need_defcfg,  m_need);
    chk("R12 coldstart",   coldstart_en, m_cold);
    chk("R9 all_slots",    all_slots,    m_all);
    chk("R12 wakeup",      wakeup_pulse, m_wake);
  endtask

  // advance model across one edge with the inputs about to be sampled
  task automatic model_step(input logic wr, input logic [15:0] d, input logic rdy, input logic ce);
    logic acc, eff, issue, bad;
    logic [3:0] c;
    acc   = m_busy && rdy;
    c     = m_field;
    eff   = acc && (!m_need || c == 4'b0110);
    issue = wr && !d[4];
    bad   = issue && (m_busy || f_res(d[3:0]));
    m_wake = 1'b0;
    if (m_pend && ce) begin
      m_pend = 1'b0;
      if (m_pcode == 4'b0111) m_state = 3'd4; else m_all = 1'b1;
    end
    if (eff) begin
      case (c)
        4'b0000: m_cold = 1'b1;
        4'b0001, 4'b0111: begin m_pend = 1'b1; m_pcode = c; end
        4'b0010: begin m_state = 3'd1; m_cold = 1'b0; m_all = 1'b0; end
        4'b0011: begin m_state = 3'd4; m_pend = 1'b0; end
        4'b0100: m_state = 3'd2;
        4'b0101: m_state = 3'd3;
        4'b0110: begin m_state = 3'd0; m_need = 1'b0; m_cold = 1'b0; m_all = 1'b0; end
        4'b1000: m_wake = 1'b1;
        4'b1100: begin m_need = 1'b1; m_pend = 1'b0; end
        default: ;
      endcase
    end
    if (acc) m_busy = 1'b0;
    if (issue && !bad) begin m_busy = 1'b1; m_field = d[3:0]; end
    if (bad) m_ill = 1'b1;
    else if (wr && d[8]) m_ill = 1'b0;
  endtask

  task automatic cyc(input logic wr, input logic [15:0] d, input logic rdy, input logic ce);
    @(negedge clk);
    compare_all();
    host_wr = wr; host_wdata = d; eng_ready = rdy; cycle_end = ce;
    model_step(wr, d, rdy, ce);
  endtask

  task automatic issue_cmd(input logic [3:0] c);
    cyc(1'b1, {12'h000, c}, 1'b0, 1'b0);
    cyc(1'b0, 16'h0, 1'b1, 1'b0);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_busy = 0; m_ill = 0; m_need = 0; m_cold = 0; m_all = 0; m_wake = 0; m_pend = 0;
    m_field = 0; m_pcode = 0; m_state = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1 busy", busy, 0); chk("R1 state", eng_state, 0); chk("R1 illegal", illegal, 0);
    // R3: write-mode set, no command
    cyc(1'b1, 16'h0015, 1'b1, 1'b0);
    cyc(1'b0, 16'h0, 1'b1, 1'b0);
    // R2/R4: hold then accept config
    cyc(1'b1, 16'h0002, 1'b0, 1'b0);
    cyc(1'b0, 16'h0, 1'b0, 1'b0);
    cyc(1'b0, 16'h0, 1'b0, 1'b0);
    // R5: overlapping write while busy
    cyc(1'b1, 16'h0004, 1'b1, 1'b0);
    cyc(1'b0, 16'h0, 1'b0, 1'b0);
    @(negedge clk); chk("R5 overlap illegal", illegal, 1); chk("R5 field", cmd_field, 2);
    // R7: clear, R6: reserved
    cyc(1'b1, 16'h0110, 1'b0, 1'b0);
    cyc(1'b1, 16'h000D, 1'b0, 1'b0);
    cyc(1'b1, 16'h010B, 1'b0, 1'b0);
    cyc(1'b0, 16'h0, 1'b0, 1'b0);
    // R9: delayed halt, cycle_end on acceptance edge does not count
    issue_cmd(4'b0101);
    cyc(1'b1, 16'h0007, 1'b0, 1'b0);
    cyc(1'b0, 16'h0, 1'b1, 1'b1);
    cyc(1'b0, 16'h0, 1'b0, 1'b0);
    cyc(1'b0, 16'h0, 1'b0, 1'b1);
    cyc(1'b0, 16'h0, 1'b0, 1'b0);
    // R10: all-slots then freeze cancels
    issue_cmd(4'b0010);
    issue_cmd(4'b0001);
    issue_cmd(4'b0011);
    cyc(1'b0, 16'h0, 1'b0, 1'b1);
    cyc(1'b0, 16'h0, 1'b0, 1'b0);
    @(negedge clk); chk("R10 no all_slots", all_slots, 0); chk("R10 halt", eng_state, 4);
    // R11: reset engine, blocked, then default config; R12 coldstart/wakeup
    issue_cmd(4'b1100);
    issue_cmd(4'b0100);
    issue_cmd(4'b0000);
    issue_cmd(4'b0110);
    issue_cmd(4'b0000);
    issue_cmd(4'b1000);
    cyc(1'b0, 16'h0, 1'b0, 1'b0);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] d;
      logic [3:0] c;
      c = ($urandom % 4 == 0) ? 4'($urandom) : 4'($urandom % 9);
      if (c == 4'b1000 && ($urandom % 3 == 0)) c = 4'b1100;
      d = {7'h0, ($urandom % 6 == 0), 3'h0, ($urandom % 6 == 0), c};
      cyc(($urandom % 3 == 0), d, ($urandom % 2 == 0), ($urandom % 7 == 0));
    end
    cyc(1'b0, 16'h0, 1'b0, 1'b0);
    @(negedge clk);
    compare_all();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule